// File: doc/BRIEF.md
# Scintillator Coincidence Trigger

This block turns 32 discriminated photosensor hit lines into a trigger for a two-plane scintillator detector. The lines come in on two cables of 16 lines each. Each line can be turned off one by one. Pairs of lines, one from each end of a scintillator bar, are combined with an AND, which gives eight bar signals per cable. On each cable, the bars that a per-bar enable lets through are combined with an OR into one group signal. The first cable gives group A and the second gives group B.

A 16-bit control word selects the trigger condition. One code fires on either group, another code fires only when both groups are present, and every other value turns the trigger off. The two group signals and their coincidence also leave the block on three extra timing channels, so a time-to-digital stage can record them next to the raw hits. The hit lines are asynchronous and pass through a synchronizer. The trigger output is a registered single-cycle pulse that fires once for each continuous stretch of the selected condition.

Top module: `sc_coinc_trigger`

## Requirements
- R1: A change on `hitIn` shows on `timingOut` after the third rising clock edge, and the trigger pulse it causes is high for the clock cycle after the fourth edge.
- R2: A zero in bit n of `tdcMask` removes hit line n before any other logic. Line n then cannot take part in any bar.
- R3: A bar signal is high only while both of its end lines are high and enabled. One end alone gives no bar.
- R4: Bar k of a cable (k = 0..7, offsets measured from the cable's first line) uses one end line from the list 0, 1, 10, 11, 2, 3, 8, 9 and the other end line from the list 14, 15, 6, 7, 12, 13, 4, 5, taking entry k of each list. Cable A covers lines 0-15 and cable B covers lines 16-31.
- R5: Group A is the OR of the cable-A bars k whose `trgMask[k]` is 1. Group B is the OR of the cable-B bars k whose `trgMask[8+k]` is 1.
- R6: `timingOut[0]` carries A, `timingOut[1]` carries B and `timingOut[2]` carries A AND B, whatever the control word holds.
- R7: With `ctrlWord` = 16'hC0FE, the condition is A OR B.
- R8: With `ctrlWord` = 16'hC0F0, the condition is A AND B, so a single group does not trigger.
- R9: Every other `ctrlWord` value keeps `trigPulse` low.
- R10: `trigPulse` lasts exactly one cycle, and it fires only once for each continuous run of the condition. If the condition drops for a single cycle, the trigger re-arms and a second pulse follows.
- R11: While `rstN` is low, all outputs are zero. Mask and control copies reset to zero, so after reset nothing passes until a configuration is applied. A new configuration takes effect one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitIn | input | 32 | Asynchronous hit lines; bits 0-15 are cable A, bits 16-31 are cable B |
| tdcMask | input | 32 | Per-line enable, 1 = line used |
| trgMask | input | 16 | Per-bar enable; bits 7:0 for cable A, bits 15:8 for cable B |
| ctrlWord | input | 16 | Trigger mode code |
| timingOut | output | 3 | Registered A, B and A AND B timing channels |
| trigPulse | output | 1 | Registered single-cycle trigger pulse |

## Verification
Two functions can land on the same clock edge. One is the re-arm that happens when the selected condition goes low. The other is the condition coming back on the very next cycle. If re-arming does not finish before the returning condition is sampled, the second pulse is lost. The bench provokes this by holding a coincidence, dropping one of the hit lines for exactly one clock cycle, and then raising it again. It counts the pulses in a window and expects two. A separate long, unbroken coincidence must give exactly one pulse.

// File: rtl/sc_trig_pkg.sv
package sc_trig_pkg;

  localparam logic [15:0] CODE_EITHER = 16'hC0FE;
  localparam logic [15:0] CODE_BOTH   = 16'hC0F0;

  typedef struct packed {
    logic modeEither;
    logic modeBoth;
  } modeStrb_t;

  // Offset of the first end line of bar k inside one cable.
  function automatic int firstEnd(input int k);
    int base;
    case (k / 2)
      0:       base = 0;
      1:       base = 10;
      2:       base = 2;
      default: base = 8;
    endcase
    return base + (k % 2);
  endfunction

  // Offset of the opposite end line of bar k inside one cable.
  function automatic int secondEnd(input int k);
    int base;
    case (k / 2)
      0:       base = 14;
      1:       base = 6;
      2:       base = 12;
      default: base = 4;
    endcase
    return base + (k % 2);
  endfunction

endpackage

// File: rtl/sc_trig_datapath.sv
module sc_trig_datapath
  import sc_trig_pkg::*;
#(
  parameter int CABLE_W     = 16,
  parameter int BARS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*CABLE_W-1:0]   hitIn,
  input  logic [2*CABLE_W-1:0]   tdcMaskIn,
  input  logic [2*BARS-1:0]      trgMaskIn,
  input  modeStrb_t              modeStrb,
  output logic [2:0]             grpQ,
  output logic                   condQ
);

  localparam int HITS  = 2 * CABLE_W;
  localparam int NBARS = 2 * BARS;

  logic [SYNC_STAGES-1:0][HITS-1:0] syncPipe;
  logic [HITS-1:0]  tdcMaskQ;
  logic [NBARS-1:0] trgMaskQ;
  logic [HITS-1:0]  hitMasked;
  logic [NBARS-1:0] barSig;
  logic [NBARS-1:0] barGated;
  logic             grpA;
  logic             grpB;
  logic             condNext;

  // synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= hitIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= '0;
      else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  // configuration copies
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tdcMaskQ <= '0;
      trgMaskQ <= '0;
    end else begin
      tdcMaskQ <= tdcMaskIn;
      trgMaskQ <= trgMaskIn;
    end
  end

  assign hitMasked = syncPipe[SYNC_STAGES-1] & tdcMaskQ;

  // bar forming: both ends of each bar must fire
  for (genvar c = 0; c < 2; c++) begin : g_cable
    for (genvar k = 0; k < BARS; k++) begin : g_bar
      localparam int EndA = c * CABLE_W + firstEnd(k);
      localparam int EndB = c * CABLE_W + secondEnd(k);
      assign barSig[c*BARS+k] = hitMasked[EndA] & hitMasked[EndB];
    end
  end

  assign barGated = barSig & trgMaskQ;
  assign grpA     = |barGated[BARS-1:0];
  assign grpB     = |barGated[NBARS-1:BARS];

  always_comb begin
    condNext = 1'b0;
    if (modeStrb.modeEither) condNext = grpA | grpB;
    if (modeStrb.modeBoth)   condNext = grpA & grpB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpQ  <= '0;
      condQ <= 1'b0;
    end else begin
      grpQ  <= {grpA & grpB, grpB, grpA};
      condQ <= condNext;
    end
  end

endmodule

// File: rtl/sc_trig_control.sv
module sc_trig_control
  import sc_trig_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              condQ,
  output modeStrb_t         modeStrb,
  output logic              trigPulse
);

  logic [CTRL_W-1:0] ctrlQ;
  logic              armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlIn;
  end

  always_comb begin
    modeStrb = '0;
    if (ctrlQ == CTRL_W'(CODE_EITHER)) modeStrb.modeEither = 1'b1;
    if (ctrlQ == CTRL_W'(CODE_BOTH))   modeStrb.modeBoth   = 1'b1;
  end

  // one pulse per continuous condition; re-arm when it drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b1;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= condQ & armed;
      if (!condQ)     armed <= 1'b1;
      else if (armed) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_coinc_trigger.sv
module sc_coinc_trigger
  import sc_trig_pkg::*;
#(
  parameter int CABLE_W     = 16,
  parameter int BARS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*CABLE_W-1:0] hitIn,
  input  logic [2*CABLE_W-1:0] tdcMask,
  input  logic [2*BARS-1:0]    trgMask,
  input  logic [CTRL_W-1:0]    ctrlWord,
  output logic [2:0]           timingOut,
  output logic                 trigPulse
);

  modeStrb_t modeStrb;
  logic      condQ;

  sc_trig_datapath #(
    .CABLE_W(CABLE_W), .BARS(BARS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .tdcMaskIn(tdcMask),
    .trgMaskIn(trgMask), .modeStrb(modeStrb), .grpQ(timingOut), .condQ(condQ)
  );

  sc_trig_control #(.CTRL_W(CTRL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlWord), .condQ(condQ),
    .modeStrb(modeStrb), .trigPulse(trigPulse)
  );

endmodule

// File: rtl/sc_trig_checker.sv
module sc_trig_checker
  import sc_trig_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic [2:0] timingOut,
  input logic      trigPulse,
  input modeStrb_t modeStrb
);

  // R10: pulse is one cycle wide
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R10: a pulse follows a present group
  a_r10_group_seen: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(|timingOut[1:0]));

  // R8: coincidence mode needs both groups
  a_r8_both_groups: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(modeStrb.modeBoth, 2)) |-> $past(timingOut[2]));

  // R9: undefined code gives no pulse
  a_r9_bad_code_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStrb.modeEither && !modeStrb.modeBoth) |-> ##2 !trigPulse);

  // R11: outputs quiet when reset is released
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!trigPulse && timingOut == 3'b000));

endmodule

bind sc_coinc_trigger sc_trig_checker u_chk (
  .clk(clk), .rstN(rstN), .timingOut(timingOut),
  .trigPulse(trigPulse), .modeStrb(modeStrb)
);

// File: tb/sc_coinc_trigger_bench.sv
module sc_coinc_trigger_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hitIn = '0;
  logic [31:0] tdcMask = '0;
  logic [15:0] trgMask = '0;
  logic [15:0] ctrlWord = '0;
  logic [2:0]  timingOut;
  logic        trigPulse;

  int checks = 0;
  int fails  = 0;

  int endOne[8] = '{0, 1, 10, 11, 2, 3, 8, 9};
  int endTwo[8] = '{14, 15, 6, 7, 12, 13, 4, 5};

  always #2.5 clk = ~clk;

  sc_coinc_trigger u_sc_coinc_trigger (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .tdcMask(tdcMask),
    .trgMask(trgMask), .ctrlWord(ctrlWord), .timingOut(timingOut),
    .trigPulse(trigPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] barHits(input int cable, input int k);
    return (32'd1 << (cable*16 + endOne[k])) | (32'd1 << (cable*16 + endTwo[k]));
  endfunction

  task automatic setCfg(input logic [31:0] t, input logic [15:0] g, input logic [15:0] c);
    @(negedge clk);
    tdcMask = t; trgMask = g; ctrlWord = c;
    repeat (2) @(negedge clk);
  endtask

  // drive hits, sample timing channels after the third edge
  task automatic driveHits(input logic [31:0] h);
    @(negedge clk);
    hitIn = h;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearHits();
    @(negedge clk);
    hitIn = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trigPulse) cnt++;
    end
  endtask

  task automatic testReset();
    chk("R11 reset timing", {29'd0, timingOut}, 32'd0);
    chk("R11 reset pulse", {31'd0, trigPulse}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    driveHits('1);
    @(negedge clk);
    chk("R11 zero masks block timing", {29'd0, timingOut}, 32'd0);
    chk("R11 zero ctrl blocks pulse", {31'd0, trigPulse}, 32'd0);
    clearHits();
  endtask

  task automatic testLatency();
    setCfg('1, '1, 16'hC0FE);
    @(negedge clk);
    hitIn = barHits(0, 0);
    repeat (2) @(negedge clk);
    chk("R1 not yet after two edges", {29'd0, timingOut}, 32'd0);
    @(negedge clk);
    chk("R1 timing after third edge", {29'd0, timingOut}, 32'd1);
    chk("R1 no pulse yet", {31'd0, trigPulse}, 32'd0);
    @(negedge clk);
    chk("R1 pulse after fourth edge", {31'd0, trigPulse}, 32'd1);
    @(negedge clk);
    chk("R10 pulse width", {31'd0, trigPulse}, 32'd0);
    clearHits();
  endtask

  task automatic testPairing();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 8; k++) begin
        setCfg('1, 16'd1 << (c*8 + k), 16'h0000);
        driveHits(barHits(c, k));
        chk($sformatf("R4 R5 cable %0d bar %0d own ends", c, k),
            {29'd0, timingOut}, (c == 0) ? 32'd1 : 32'd2);
        driveHits(~barHits(c, k));
        chk($sformatf("R4 cable %0d bar %0d other lines", c, k),
            {29'd0, timingOut}, 32'd0);
        clearHits();
      end
    end
  endtask

  task automatic testEndsAndMask();
    setCfg('1, '1, 16'hC0FE);
    driveHits(32'd1 << endOne[2]);
    chk("R3 single end no bar", {29'd0, timingOut}, 32'd0);
    driveHits(32'd1 << (16 + endTwo[5]));
    chk("R3 single far end no bar", {29'd0, timingOut}, 32'd0);
    clearHits();
    setCfg(~(32'd1 << (16 + endOne[3])), '1, 16'hC0FE);
    driveHits(barHits(1, 3));
    chk("R2 masked line kills bar", {29'd0, timingOut}, 32'd0);
    driveHits(barHits(1, 3) | barHits(1, 4));
    chk("R2 other bar still works", {29'd0, timingOut}, 32'd2);
    clearHits();
    setCfg('1, 16'hFF00, 16'hC0FE);
    driveHits(32'h0000FFFF);
    chk("R5 cable A bars disabled", {29'd0, timingOut}, 32'd0);
    clearHits();
  endtask

  task automatic testModes();
    int cnt;
    setCfg('1, '1, 16'h0000);
    driveHits(barHits(0, 6) | barHits(1, 1));
    chk("R6 channels independent of ctrl", {29'd0, timingOut}, 32'd7);
    clearHits();

    setCfg('1, '1, 16'hC0FE);
    @(negedge clk); hitIn = barHits(1, 7);
    countPulses(12, cnt);
    chk("R7 either mode on B alone", cnt, 32'd1);
    clearHits();

    setCfg('1, '1, 16'hC0F0);
    @(negedge clk); hitIn = barHits(0, 4);
    countPulses(12, cnt);
    chk("R8 both mode ignores A alone", cnt, 32'd0);
    clearHits();
    @(negedge clk); hitIn = barHits(0, 4) | barHits(1, 2);
    countPulses(12, cnt);
    chk("R8 both mode fires on A and B", cnt, 32'd1);
    clearHits();

    setCfg('1, '1, 16'hC0FF);
    @(negedge clk); hitIn = '1;
    countPulses(12, cnt);
    chk("R9 code C0FF quiet", cnt, 32'd0);
    clearHits();
    setCfg('1, '1, 16'h0000);
    @(negedge clk); hitIn = '1;
    countPulses(12, cnt);
    chk("R9 code 0000 quiet", cnt, 32'd0);
    clearHits();
  endtask

  task automatic testRearm();
    int cnt;
    setCfg('1, '1, 16'hC0FE);
    @(negedge clk); hitIn = barHits(0, 1);
    countPulses(40, cnt);
    chk("R10 long coincidence one pulse", cnt, 32'd1);
    @(negedge clk); hitIn = '0;
    @(negedge clk); hitIn = barHits(0, 1);
    countPulses(12, cnt);
    chk("R10 one-cycle gap re-arms", cnt, 32'd1);
    clearHits();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    testLatency();
    testPairing();
    testEndsAndMask();
    testModes();
    testRearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule